// File: doc/BRIEF.md
# Mailbox Receive Message Queue

This block is the receiving half of an inter-processor mailbox. Remote senders present messages as a channel number plus a 64-bit payload on a valid/ready stream. Each accepted message goes into a circular queue of `DEPTH` entries. The queue raises an interrupt while it holds anything, unless that interrupt is masked.

Software works through a small register window. It reads the oldest message through three read-only registers: the channel number, the low payload word and the high payload word. Reading these registers has no side effect. To release the message, software writes a pop command. A status register shows the raw write and read positions and a full flag. Software can work out the occupancy from these. A FIFO clear command, an interrupt mask register and a clearable interrupt-status bit complete the window.

Back-pressure on the stream follows these rules. `in_ready` is high exactly when the queue is not full. A transfer completes on a clock edge where `in_valid` and `in_ready` are both high. A sender facing a full queue must hold its message until `in_ready` returns. A transfer that completes in the same cycle as a FIFO clear is discarded.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the queue is empty, `in_ready` is 1, `irq` is 0, the status register reads 0, the interrupt-status register reads 0 and the mask register reads 0x1F.
- R2: A completed transfer stores the message at the current write position. The write position then advances by one and wraps from DEPTH-1 to 0.
- R3: When the queue is full, `in_ready` is 0. Holding `in_valid` high stores nothing and leaves the write position unchanged.
- R4: Offset 0x00 returns the head channel number in its low bits. Offset 0x04 returns payload bits 31:0 and offset 0x08 returns payload bits 63:32. These reads change no state, and all three return 0 when the queue is empty.
- R5: A write to offset 0x0C with bit 0 set drops the head entry and advances the read position modulo DEPTH. The write does nothing if bit 0 is clear or if the queue is empty.
- R6: The status register at offset 0x14 holds the read position in bits 31:24, the write position in bits 23:16 and the full flag in bit 0. When the two positions are equal, bit 0 tells a full queue apart from an empty one.
- R7: Writing the value 0 to offset 0x10 returns both positions and the full flag to 0. Any nonzero value written there is ignored. The clear takes priority over a push or pop in the same cycle.
- R8: A push and a pop in the same cycle both take effect, and the occupancy stays the same.
- R9: The register at offset 0x24 reads DEPTH-1.
- R10: Interrupt-status bit 0, at offset 0x18, becomes 1 one cycle after a cycle in which the queue is non-empty and mask bit 0 is clear. The `irq` output equals this bit. Writing 1 to bit 0 clears it, unless the set condition holds in that same cycle.
- R11: The mask register at offset 0x1C holds 5 writable bits. While mask bit 0 is 1, the interrupt-status bit does not become set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Queue can accept a message |
| in_chan | input | CHAN_W | Channel number of incoming message |
| in_data | input | 64 | Incoming payload |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Not-empty interrupt |

## Verification
The bench makes an incoming transfer and a software pop land in the same cycle. It drives `in_valid` in the same cycle as the pop-command write, both while the queue holds one entry and while it is nearly full. After each such cycle it checks that both positions advance together, that the full flag does not change and that the head message matches the one next in line. A second collision puts an incoming transfer in the same cycle as a FIFO clear; the check is that the status reads 0 afterwards. A third writes the interrupt clear while the queue is still non-empty and unmasked; the check is that `irq` stays high.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
  localparam logic [5:0] OFS_CHAN  = 6'h00;
  localparam logic [5:0] OFS_LO    = 6'h04;
  localparam logic [5:0] OFS_HI    = 6'h08;
  localparam logic [5:0] OFS_POP   = 6'h0C;
  localparam logic [5:0] OFS_CLR   = 6'h10;
  localparam logic [5:0] OFS_STAT  = 6'h14;
  localparam logic [5:0] OFS_ISTS  = 6'h18;
  localparam logic [5:0] OFS_IMSK  = 6'h1C;
  localparam logic [5:0] OFS_DEPTH = 6'h24;
  localparam int         MASK_W    = 5;
  localparam int         POS_W     = 8;
endpackage

// File: rtl/mbox_rx_store.sv
module mbox_rx_store #(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              full,
  output logic              empty,
  output logic [CHAN_W-1:0] head_chan,
  output logic [DATA_W-1:0] head_data
);
  localparam int ENT_W = CHAN_W + DATA_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_inc, rd_inc;

  assign wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  assign empty  = (wr_ptr == rd_ptr) && !full;
  assign {head_chan, head_data} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= {push_chan, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_inc;
      if (pop)  rd_ptr <= rd_inc;
      if (push && !pop)      full <= (wr_inc == rd_ptr);
      else if (pop && !push) full <= 1'b0;
    end
  end

  // R2: write position steps by one after a push
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && wr_ptr != LAST) |=> (wr_ptr == $past(wr_ptr) + 1'b1));
  // R3: full queue without pop or clear keeps its write position
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> $stable(wr_ptr));
  // R5: pop advances the read position
  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush && rd_ptr != LAST) |=> (rd_ptr == $past(rd_ptr) + 1'b1));
  // R6: full only with equal positions
  a_r6_full_equal: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wr_ptr == rd_ptr));
  // R7: clear empties the queue
  a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr == '0 && rd_ptr == '0 && !full));
endmodule

// File: rtl/mbox_rx_regs.sv
module mbox_rx_regs
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic              full,
  input  logic              empty,
  input  logic [CHAN_W-1:0] head_chan,
  input  logic [63:0]       head_data,
  output logic [31:0]       reg_rdata,
  output logic              pop,
  output logic              flush,
  output logic              irq
);
  logic [MASK_W-1:0] mask_q;
  logic              ists_q;
  logic              ists_clr, ists_set;
  logic [POS_W-1:0]  wr_pos, rd_pos;

  assign wr_pos   = POS_W'(wr_ptr);
  assign rd_pos   = POS_W'(rd_ptr);
  assign pop      = reg_we && (reg_addr == OFS_POP) && reg_wdata[0] && !empty;
  assign flush    = reg_we && (reg_addr == OFS_CLR) && (reg_wdata == 32'd0);
  assign ists_clr = reg_we && (reg_addr == OFS_ISTS) && reg_wdata[0];
  assign ists_set = !empty && !mask_q[0];
  assign irq      = ists_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ists_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_IMSK) mask_q <= reg_wdata[MASK_W-1:0];
      ists_q <= (ists_q && !ists_clr) || ists_set;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CHAN:  reg_rdata = empty ? 32'd0 : 32'(head_chan);
      OFS_LO:    reg_rdata = empty ? 32'd0 : head_data[31:0];
      OFS_HI:    reg_rdata = empty ? 32'd0 : head_data[63:32];
      OFS_STAT:  reg_rdata = {rd_pos, wr_pos, 15'd0, full};
      OFS_ISTS:  reg_rdata = {31'd0, ists_q};
      OFS_IMSK:  reg_rdata = 32'(mask_q);
      OFS_DEPTH: reg_rdata = 32'(DEPTH - 1);
      default:   reg_rdata = 32'd0;
    endcase
  end

  // R10: non-empty and unmasked sets the status bit next cycle
  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !mask_q[0]) |=> irq);
  // R10: clear without a set condition drops the bit
  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ists_clr && (empty || mask_q[0])) |=> !irq);
  // R11: masked or empty never raises a clear bit
  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (empty || mask_q[0])) |=> !irq);
endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [63:0]       in_data,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              push, pop, flush, full, empty;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CHAN_W-1:0] head_chan;
  logic [63:0]       head_data;

  assign in_ready = !full;
  assign push     = in_valid && in_ready;

  mbox_rx_store #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .DATA_W(64), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_chan(in_chan), .push_data(in_data),
    .pop(pop), .flush(flush), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full),
    .empty(empty), .head_chan(head_chan), .head_data(head_data)
  );

  mbox_rx_regs #(.DEPTH(DEPTH), .CHAN_W(CHAN_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full),
    .empty(empty), .head_chan(head_chan), .head_data(head_data),
    .reg_rdata(reg_rdata), .pop(pop), .flush(flush), .irq(irq)
  );

  // R3: a full queue refuses transfers
  a_r3_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> !in_ready);
endmodule

// File: tb/mbox_rx_fifo_test.sv
`timescale 1ns/1ps
module mbox_rx_fifo_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_chan = '0;
  logic [63:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH), .CHAN_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // op: 0 push, 1 pop, 2 push and pop together
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] ewr;
    logic [7:0] erd;
    logic       efull;
  } step_t;

  localparam step_t STEPS [14] = '{
    '{2'd0, 8'd1, 8'd0, 1'b0}, '{2'd0, 8'd2, 8'd0, 1'b0},
    '{2'd1, 8'd2, 8'd1, 1'b0}, '{2'd2, 8'd3, 8'd2, 1'b0},
    '{2'd0, 8'd4, 8'd2, 1'b0}, '{2'd0, 8'd5, 8'd2, 1'b0},
    '{2'd0, 8'd6, 8'd2, 1'b0}, '{2'd0, 8'd7, 8'd2, 1'b0},
    '{2'd0, 8'd0, 8'd2, 1'b0}, '{2'd0, 8'd1, 8'd2, 1'b0},
    '{2'd0, 8'd2, 8'd2, 1'b1}, '{2'd0, 8'd2, 8'd2, 1'b1},
    '{2'd1, 8'd2, 8'd3, 1'b0}, '{2'd2, 8'd3, 8'd4, 1'b0}
  };

  logic [66:0] model [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic cyc(input logic v, input logic [2:0] ch, input logic [63:0] d,
                     input logic we, input logic [5:0] a, input logic [31:0] wd);
    in_valid = v; in_chan = ch; in_data = d;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic check_head(input string req);
    logic [31:0] v;
    logic [66:0] e;
    e = (model.size() == 0) ? 67'd0 : model[0];
    rd(6'h00, v); check(req, v, {29'd0, e[66:64]});
    rd(6'h04, v); check(req, v, e[31:0]);
    rd(6'h08, v); check(req, v, e[63:32]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(6'h14, v); check("R1 status", v, 32'd0);
    rd(6'h18, v); check("R1 irq status", v, 32'd0);
    rd(6'h1C, v); check("R1 mask", v, 32'h1F);
    rd(6'h24, v); check("R9 depth", v, DEPTH - 1);
    check_head("R4 empty head");

    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h1C, 32'd0);

    for (int i = 0; i < 14; i++) begin
      logic [63:0] d;
      logic [2:0]  ch;
      logic        dopush, dopop;
      string       tag;
      d  = {32'hC0DE_0000 | i, 32'h1234_0000 + i * 17};
      ch = 3'(i + 5);
      dopush = (STEPS[i].op != 2'd1);
      dopop  = (STEPS[i].op != 2'd0);
      tag = (STEPS[i].op == 2'd0) ? "R2" : (STEPS[i].op == 2'd1) ? "R5" : "R8";
      if (dopush && model.size() == DEPTH) begin
        tag = "R3";
        check("R3 in_ready low when full", {31'd0, in_ready}, 32'd0);
      end
      cyc(dopush, ch, d, dopop, 6'h0C, 32'd1);
      if (dopop && model.size() != 0) void'(model.pop_front());
      if (dopush && (model.size() < DEPTH - (dopop ? 1 : 0) || dopop))
        model.push_back({ch, d});
      rd(6'h14, v);
      check({tag, " R6 status"}, v, {STEPS[i].erd, STEPS[i].ewr, 15'd0, STEPS[i].efull});
      check_head({tag, " R4 head"});
    end

    // R7 nonzero clear ignored; R5 trigger with bit0 clear ignored
    s = {8'd4, 8'd3, 16'd0};
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h10, 32'd5);
    rd(6'h14, v); check("R7 nonzero clear ignored", v, s);
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h0C, 32'd2);
    rd(6'h14, v); check("R5 trigger bit0 clear ignored", v, s);
    check_head("R4 reads leave head");
    rd(6'h14, v); check("R4 reads no side effect", v, s);

    // R7 clear wins over a concurrent push
    in_valid = 1'b1; in_chan = 3'd1; in_data = 64'hFFFF;
    cyc(1'b1, 3'd1, 64'hFFFF, 1'b1, 6'h10, 32'd0);
    model.delete();
    rd(6'h14, v); check("R7 clear beats push", v, 32'd0);
    check_head("R4 empty after clear");
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h0C, 32'd1);
    rd(6'h14, v); check("R5 pop on empty ignored", v, 32'd0);

    // R10 clear when empty
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h18, 32'd1);
    check("R10 clear drops irq", {31'd0, irq}, 32'd0);

    // R11 mask width and masking
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h1C, 32'hFFFF_FFE1);
    rd(6'h1C, v); check("R11 mask width", v, 32'h01);
    cyc(1'b1, 3'd6, 64'h0123_4567_89AB_CDEF, 1'b0, 6'h00, 32'd0);
    model.push_back({3'd6, 64'h0123_4567_89AB_CDEF});
    cyc(1'b0, 3'd0, 64'd0, 1'b0, 6'h00, 32'd0);
    cyc(1'b0, 3'd0, 64'd0, 1'b0, 6'h00, 32'd0);
    check("R11 masked no irq", {31'd0, irq}, 32'd0);
    check_head("R4 head after masked push");

    // R10 latency after unmask
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h1C, 32'd0);
    check("R10 not yet set", {31'd0, irq}, 32'd0);
    cyc(1'b0, 3'd0, 64'd0, 1'b0, 6'h00, 32'd0);
    check("R10 irq set", {31'd0, irq}, 32'd1);
    rd(6'h18, v); check("R10 irq status reg", v, 32'd1);
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h18, 32'd1);
    check("R10 clear loses to set", {31'd0, irq}, 32'd1);
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h0C, 32'd1);
    void'(model.pop_front());
    cyc(1'b0, 3'd0, 64'd0, 1'b1, 6'h18, 32'd1);
    check("R10 clear after drain", {31'd0, irq}, 32'd0);
    rd(6'h14, v); check("R5 drained", v, 32'h0101_0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule